// File: doc/BRIEF.md
# Store Buffer with Load Forwarding

This block sits between a processor's load/store request port and a single-ported memory. An accepted store is held as an address/data pair in a small circular queue. The queue writes its oldest entry to memory whenever the memory port is not claimed by a load. A load is never held up behind unrelated stores. Its address is compared against every occupied entry at once. When some entry matches, the reply comes from the most recently queued matching store and memory is not touched. When nothing matches, the load reads memory ahead of the queued stores.

Only one load may be in flight. The request port stays closed from the moment a missing load is accepted until its reply has been returned. The queue-empty output lets a fence unit wait until every earlier store has reached memory.

Top module: `sq_fwd_top`

## Requirements
- R1: After reset the queue is empty (`sbEmpty`=1), `cpuReqReady` is 1, and neither `memReqValid` nor `ldRespValid` is asserted.
- R2: An accepted store (`cpuReqIsStore`=1) is held in the queue. It is not written to memory while `memReqReady` is 0, and `sbEmpty` goes to 0.
- R3: Queued stores are written to memory (`memReqWrite`=1) in the order they were accepted, with their own address and data. At most one write is accepted per cycle.
- R4: A load that misses the queue is sent to memory as a read (`memReqWrite`=0) in the cycle after it is accepted. While that read waits for `memReqReady`, no queued store is offered to memory.
- R5: A load whose address equals that of a queued store is answered one cycle after acceptance, with `ldRespValid`=1, and memory sees no read.
- R6: When several queued stores match a load address, the reply carries the data of the store accepted last.
- R7: A load that misses returns the memory contents even when older stores to other addresses are still queued.
- R8: With all DEPTH entries occupied, `cpuReqReady` is 0 for a store request and 1 for a load request.
- R9: `sbEmpty` is 1 exactly when no accepted store is still waiting to be written to memory.
- R10: After a read is accepted by memory, `cpuReqReady` stays 0 until the read data returns (`memRespValid`). `ldRespValid` is asserted, with that data, in the cycle after `memRespValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuReqValid | input | 1 | Processor request present |
| cpuReqReady | output | 1 | Request accepted this cycle when valid |
| cpuReqIsStore | input | 1 | 1 = store, 0 = load |
| cpuReqAddr | input | AW | Request address |
| cpuReqWdata | input | DW | Store data |
| ldRespValid | output | 1 | Load reply present (one-cycle pulse) |
| ldRespData | output | DW | Load reply data |
| memReqValid | output | 1 | Memory request present |
| memReqReady | input | 1 | Memory accepts the request this cycle |
| memReqWrite | output | 1 | 1 = write, 0 = read |
| memReqAddr | output | AW | Memory address |
| memReqWdata | output | DW | Memory write data |
| memRespValid | input | 1 | Read data present |
| memRespData | input | DW | Read data |
| sbEmpty | output | 1 | No store waiting in the queue |

## Verification
A mixed sequence of stores and loads runs with memory always ready. In this sequence, loads to just-stored addresses, to addresses that were overwritten, and to untouched addresses must all return program-order values, whether the reply is forwarded or read from memory. A directed run then holds memory busy while four stores fill the queue, two of them to one address. This separates forwarding of the youngest entry from forwarding of the oldest one, and it shows that a hit makes no memory read. A missing load issued in the same busy state shows read priority, bypass of the older stores and the closed request port. The write log recorded afterwards confirms the drain order and the data of each write.

// File: rtl/sq_pkg.sv
package sq_pkg;

  typedef struct packed {
    logic push;    // write the request into the tail entry
    logic pop;     // retire the head entry (write accepted by memory)
    logic capFwd;  // register forwarded data as the load reply
    logic capMem;  // register memory read data as the load reply
    logic latchLd; // hold a missing load address for the read
    logic rdSel;   // memory address comes from the held load
  } sqStrobe_t;

  typedef enum logic [1:0] {
    SQ_IDLE     = 2'd0,
    SQ_RD_ISSUE = 2'd1,
    SQ_RD_WAIT  = 2'd2
  } sqState_e;

endpackage

// File: rtl/sq_datapath.sv
module sq_datapath
  import sq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  sqStrobe_t     strobe,
  input  logic [AW-1:0] cpuReqAddr,
  input  logic [DW-1:0] cpuReqWdata,
  input  logic [DW-1:0] memRespData,
  output logic          fwdHit,
  output logic          qFull,
  output logic          qEmpty,
  output logic [AW-1:0] memReqAddr,
  output logic [DW-1:0] memReqWdata,
  output logic [DW-1:0] ldRespData
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [AW-1:0]    entAddr [DEPTH];
  logic [DW-1:0]    entData [DEPTH];
  logic [DEPTH-1:0] entValid;
  logic [PW-1:0]    headPtr;
  logic [PW-1:0]    tailPtr;
  logic [AW-1:0]    ldAddrQ;
  logic [DW-1:0]    respDataQ;
  logic [DW-1:0]    fwdData;

  function automatic logic [PW-1:0] ptrInc(input logic [PW-1:0] p);
    if (int'(p) == DEPTH - 1) return '0;
    return p + 1'b1;
  endfunction

  // Queue storage: one write port at the tail, one retire at the head.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      entValid <= '0;
      headPtr  <= '0;
      tailPtr  <= '0;
    end else begin
      if (strobe.push) begin
        entAddr[tailPtr]  <= cpuReqAddr;
        entData[tailPtr]  <= cpuReqWdata;
        tailPtr           <= ptrInc(tailPtr);
      end
      if (strobe.pop) begin
        headPtr <= ptrInc(headPtr);
      end
      for (int i = 0; i < DEPTH; i++) begin
        if (strobe.push && (int'(tailPtr) == i)) begin
          entValid[i] <= 1'b1;
        end else if (strobe.pop && (int'(headPtr) == i)) begin
          entValid[i] <= 1'b0;
        end
      end
    end
  end

  // Associative compare walked from oldest to youngest: the last hit wins.
  always_comb begin
    fwdHit  = 1'b0;
    fwdData = '0;
    for (int k = 0; k < DEPTH; k++) begin
      int idx;
      idx = int'(headPtr) + k;
      if (idx >= DEPTH) idx = idx - DEPTH;
      if (entValid[idx] && (entAddr[idx] == cpuReqAddr)) begin
        fwdHit  = 1'b1;
        fwdData = entData[idx];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ldAddrQ   <= '0;
      respDataQ <= '0;
    end else begin
      if (strobe.latchLd) ldAddrQ <= cpuReqAddr;
      if (strobe.capFwd) begin
        respDataQ <= fwdData;
      end else if (strobe.capMem) begin
        respDataQ <= memRespData;
      end
    end
  end

  assign qFull       = &entValid;
  assign qEmpty      = ~|entValid;
  assign memReqAddr  = strobe.rdSel ? ldAddrQ : entAddr[headPtr];
  assign memReqWdata = entData[headPtr];
  assign ldRespData  = respDataQ;

endmodule

// File: rtl/sq_control.sv
module sq_control
  import sq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cpuReqValid,
  input  logic      cpuReqIsStore,
  input  logic      fwdHit,
  input  logic      qFull,
  input  logic      qEmpty,
  input  logic      memReqReady,
  input  logic      memRespValid,
  output logic      cpuReqReady,
  output logic      memReqValid,
  output logic      memReqWrite,
  output logic      ldRespValid,
  output sqStrobe_t strobe
);

  sqState_e state;
  sqState_e stateNext;
  logic     reqAcc;
  logic     ldAcc;
  logic     rdIssue;

  assign cpuReqReady = (state == SQ_IDLE) && !(cpuReqIsStore && qFull);
  assign reqAcc      = cpuReqValid && cpuReqReady;
  assign ldAcc       = reqAcc && !cpuReqIsStore;
  assign rdIssue     = (state == SQ_RD_ISSUE);

  // A pending read owns the port; otherwise the head store is offered.
  assign memReqValid = rdIssue || !qEmpty;
  assign memReqWrite = !rdIssue;

  always_comb begin
    strobe.push    = reqAcc && cpuReqIsStore;
    strobe.pop     = !rdIssue && !qEmpty && memReqReady;
    strobe.capFwd  = ldAcc && fwdHit;
    strobe.latchLd = ldAcc && !fwdHit;
    strobe.capMem  = (state == SQ_RD_WAIT) && memRespValid;
    strobe.rdSel   = rdIssue;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      SQ_IDLE:     if (strobe.latchLd) stateNext = SQ_RD_ISSUE;
      SQ_RD_ISSUE: if (memReqReady)    stateNext = SQ_RD_WAIT;
      SQ_RD_WAIT:  if (memRespValid)   stateNext = SQ_IDLE;
      default:                         stateNext = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= SQ_IDLE;
      ldRespValid <= 1'b0;
    end else begin
      state       <= stateNext;
      ldRespValid <= strobe.capFwd || strobe.capMem;
    end
  end

endmodule

// File: rtl/sq_fwd_top.sv
module sq_fwd_top
  import sq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cpuReqValid,
  output logic          cpuReqReady,
  input  logic          cpuReqIsStore,
  input  logic [AW-1:0] cpuReqAddr,
  input  logic [DW-1:0] cpuReqWdata,
  output logic          ldRespValid,
  output logic [DW-1:0] ldRespData,
  output logic          memReqValid,
  input  logic          memReqReady,
  output logic          memReqWrite,
  output logic [AW-1:0] memReqAddr,
  output logic [DW-1:0] memReqWdata,
  input  logic          memRespValid,
  input  logic [DW-1:0] memRespData,
  output logic          sbEmpty
);

  sqStrobe_t strobe;
  logic      fwdHit;
  logic      qFull;
  logic      qEmpty;

  sq_control ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .cpuReqValid  (cpuReqValid),
    .cpuReqIsStore(cpuReqIsStore),
    .fwdHit       (fwdHit),
    .qFull        (qFull),
    .qEmpty       (qEmpty),
    .memReqReady  (memReqReady),
    .memRespValid (memRespValid),
    .cpuReqReady  (cpuReqReady),
    .memReqValid  (memReqValid),
    .memReqWrite  (memReqWrite),
    .ldRespValid  (ldRespValid),
    .strobe       (strobe)
  );

  sq_datapath #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cpuReqAddr (cpuReqAddr),
    .cpuReqWdata(cpuReqWdata),
    .memRespData(memRespData),
    .fwdHit     (fwdHit),
    .qFull      (qFull),
    .qEmpty     (qEmpty),
    .memReqAddr (memReqAddr),
    .memReqWdata(memReqWdata),
    .ldRespData (ldRespData)
  );

  assign sbEmpty = qEmpty;

endmodule

// File: rtl/sq_fwd_chk.sv
module sq_fwd_chk #(
  parameter int DEPTH = 4,
  parameter int AW    = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic          cpuReqValid,
  input logic          cpuReqReady,
  input logic          cpuReqIsStore,
  input logic          ldRespValid,
  input logic          memReqValid,
  input logic          memReqReady,
  input logic          memReqWrite,
  input logic [AW-1:0] memReqAddr,
  input logic          memRespValid,
  input logic          sbEmpty
);

  localparam int OW = $clog2(DEPTH + 1) + 1;

  logic [OW-1:0] occ;
  logic          rdOut;
  logic          stAcc;
  logic          wrFire;
  logic          rdFire;
  logic          ldAcc;

  assign stAcc  = cpuReqValid && cpuReqReady && cpuReqIsStore;
  assign ldAcc  = cpuReqValid && cpuReqReady && !cpuReqIsStore;
  assign wrFire = memReqValid && memReqReady && memReqWrite;
  assign rdFire = memReqValid && memReqReady && !memReqWrite;

  // Port-level bookkeeping: stores in minus writes out, and reads in flight.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      occ   <= '0;
      rdOut <= 1'b0;
    end else begin
      occ <= occ + OW'(stAcc) - OW'(wrFire);
      if (rdFire)            rdOut <= 1'b1;
      else if (memRespValid) rdOut <= 1'b0;
    end
  end

  // R9
  a_r9_empty_tracks: assert property (@(posedge clk) disable iff (!rstN)
    sbEmpty == (occ == '0));

  // R8
  a_r8_full_blocks_store: assert property (@(posedge clk) disable iff (!rstN)
    (occ == OW'(DEPTH)) |-> !stAcc);

  // R3
  a_r3_no_write_when_empty: assert property (@(posedge clk) disable iff (!rstN)
    (occ == '0) |-> !(memReqValid && memReqWrite));

  // R4
  a_r4_read_held: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqWrite && !memReqReady) |=>
      (memReqValid && !memReqWrite && $stable(memReqAddr)));

  // R10
  a_r10_single_load: assert property (@(posedge clk) disable iff (!rstN)
    rdOut |-> !ldAcc);

  // R10
  a_r10_resp_follows: assert property (@(posedge clk) disable iff (!rstN)
    (rdOut && memRespValid) |=> ldRespValid);

endmodule

bind sq_fwd_top sq_fwd_chk #(.DEPTH(DEPTH), .AW(AW)) chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .cpuReqValid  (cpuReqValid),
  .cpuReqReady  (cpuReqReady),
  .cpuReqIsStore(cpuReqIsStore),
  .ldRespValid  (ldRespValid),
  .memReqValid  (memReqValid),
  .memReqReady  (memReqReady),
  .memReqWrite  (memReqWrite),
  .memReqAddr   (memReqAddr),
  .memRespValid (memRespValid),
  .sbEmpty      (sbEmpty)
);

// File: tb/sq_fwd_top_tb.sv
`timescale 1ns/1ps
module sq_fwd_top_tb_top;

  localparam int DEPTH = 4;

  typedef struct packed {
    logic        st;
    logic [31:0] a;
    logic [31:0] d;
    logic [31:0] e;
  } vec_t;

  // Memory word i starts as 0xA000_0000 + i, word index = addr[5:2].
  localparam vec_t VEC [12] = '{
    '{1'b1, 32'h04, 32'h1111_1111, 32'h0},
    '{1'b1, 32'h08, 32'h2222_2222, 32'h0},
    '{1'b0, 32'h04, 32'h0,         32'h1111_1111},
    '{1'b0, 32'h0C, 32'h0,         32'hA000_0003},
    '{1'b1, 32'h04, 32'h3333_3333, 32'h0},
    '{1'b1, 32'h04, 32'h4444_4444, 32'h0},
    '{1'b0, 32'h04, 32'h0,         32'h4444_4444},
    '{1'b0, 32'h10, 32'h0,         32'hA000_0004},
    '{1'b1, 32'h10, 32'h5555_5555, 32'h0},
    '{1'b0, 32'h10, 32'h0,         32'h5555_5555},
    '{1'b0, 32'h08, 32'h0,         32'h2222_2222},
    '{1'b0, 32'h3C, 32'h0,         32'hA000_000F}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuReqValid = 1'b0;
  logic        cpuReqReady;
  logic        cpuReqIsStore = 1'b0;
  logic [31:0] cpuReqAddr = '0;
  logic [31:0] cpuReqWdata = '0;
  logic        ldRespValid;
  logic [31:0] ldRespData;
  logic        memReqValid;
  logic        memReqReady = 1'b1;
  logic        memReqWrite;
  logic [31:0] memReqAddr;
  logic [31:0] memReqWdata;
  logic        memRespValid = 1'b0;
  logic [31:0] memRespData = '0;
  logic        sbEmpty;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [31:0] memArr [16];
  logic [31:0] wrAddrLog [64];
  logic [31:0] wrDataLog [64];
  int wrCnt = 0;
  int rdCnt = 0;

  always #2.5 clk = ~clk;

  sq_fwd_top #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rstN(rstN),
    .cpuReqValid(cpuReqValid), .cpuReqReady(cpuReqReady),
    .cpuReqIsStore(cpuReqIsStore), .cpuReqAddr(cpuReqAddr),
    .cpuReqWdata(cpuReqWdata),
    .ldRespValid(ldRespValid), .ldRespData(ldRespData),
    .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memReqWrite(memReqWrite), .memReqAddr(memReqAddr),
    .memReqWdata(memReqWdata),
    .memRespValid(memRespValid), .memRespData(memRespData),
    .sbEmpty(sbEmpty)
  );

  // Memory model: one request per cycle, read data one cycle later.
  initial begin
    for (int i = 0; i < 16; i++) memArr[i] = 32'hA000_0000 + i;
  end

  always @(posedge clk) begin
    memRespValid <= 1'b0;
    if (rstN && memReqValid && memReqReady) begin
      if (memReqWrite) begin
        memArr[memReqAddr[5:2]] <= memReqWdata;
        if (wrCnt < 64) begin
          wrAddrLog[wrCnt] <= memReqAddr;
          wrDataLog[wrCnt] <= memReqWdata;
        end
        wrCnt <= wrCnt + 1;
      end else begin
        memRespValid <= 1'b1;
        memRespData  <= memArr[memReqAddr[5:2]];
        rdCnt        <= rdCnt + 1;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic st, input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    cpuReqValid = 1'b1; cpuReqIsStore = st; cpuReqAddr = a; cpuReqWdata = d;
    #1;
    while (!cpuReqReady) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    cpuReqValid = 1'b0;
  endtask

  task automatic waitResp(output logic [31:0] d, output logic got);
    got = 1'b0;
    d = '0;
    for (int n = 0; n < 40 && !got; n++) begin
      @(negedge clk);
      if (ldRespValid) begin
        got = 1'b1;
        d = ldRespData;
      end
    end
  endtask

  task automatic waitEmpty();
    for (int n = 0; n < 40 && !sbEmpty; n++) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic got;
    int rdBase;
    int wrBase;

    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: reset state, probed with a store request withdrawn before the edge.
    @(negedge clk);
    cpuReqValid = 1'b1; cpuReqIsStore = 1'b1;
    #0.5;
    check("R1 ready", {31'd0, cpuReqReady}, 32'd1);
    check("R1 empty", {31'd0, sbEmpty}, 32'd1);
    check("R1 memReqValid", {31'd0, memReqValid}, 32'd0);
    check("R1 ldRespValid", {31'd0, ldRespValid}, 32'd0);
    cpuReqValid = 1'b0;

    // Vector walk: every load must see the latest earlier store (R5, R7).
    foreach (VEC[i]) begin
      issue(VEC[i].st, VEC[i].a, VEC[i].d);
      if (!VEC[i].st) begin
        waitResp(rd, got);
        check($sformatf("R5/R7 vec%0d load data", i), got ? rd : 32'hDEAD_BEEF, VEC[i].e);
      end
    end
    waitEmpty();
    check("R9 empty after walk", {31'd0, sbEmpty}, 32'd1);

    // Directed: hold memory busy and fill the queue.
    @(negedge clk);
    memReqReady = 1'b0;
    wrBase = wrCnt;
    rdBase = rdCnt;
    issue(1'b1, 32'h20, 32'hD000_0001);
    issue(1'b1, 32'h24, 32'hD000_0002);
    issue(1'b1, 32'h20, 32'hD000_0003);
    issue(1'b1, 32'h28, 32'hD000_0004);
    @(negedge clk);
    check("R2 no write while busy", wrCnt, wrBase);
    check("R2 not empty", {31'd0, sbEmpty}, 32'd0);

    // R8: full queue refuses a store, accepts a load.
    cpuReqValid = 1'b1; cpuReqIsStore = 1'b1; cpuReqAddr = 32'h30;
    #0.5;
    check("R8 store ready when full", {31'd0, cpuReqReady}, 32'd0);
    cpuReqIsStore = 1'b0; cpuReqAddr = 32'h20;
    #0.5;
    check("R8 load ready when full", {31'd0, cpuReqReady}, 32'd1);
    cpuReqValid = 1'b0;

    // R5, R6: two entries match 0x20; the later one (D3) must be returned.
    issue(1'b0, 32'h20, 32'h0);
    check("R5 hit reply next cycle", {31'd0, ldRespValid}, 32'd1);
    check("R6 youngest data", ldRespData, 32'hD000_0003);
    @(negedge clk);
    check("R5 no memory read on hit", rdCnt, rdBase);

    // R4, R10: a missing load takes the port ahead of four pending stores.
    issue(1'b0, 32'h2C, 32'h0);
    cpuReqValid = 1'b1; cpuReqIsStore = 1'b0; cpuReqAddr = 32'h04;
    #0.5;
    check("R10 ready low during load", {31'd0, cpuReqReady}, 32'd0);
    cpuReqValid = 1'b0;
    @(negedge clk);
    check("R4 read offered", {31'd0, memReqValid & ~memReqWrite}, 32'd1);
    check("R4 read address", memReqAddr, 32'h2C);
    memReqReady = 1'b1;
    waitResp(rd, got);
    check("R7 bypass data", got ? rd : 32'hDEAD_BEEF, 32'hA000_000B);
    check("R4 read before any write", (wrCnt - wrBase) <= 2 ? 32'd1 : 32'd0, 32'd1);

    // R3: drain order and contents.
    waitEmpty();
    @(negedge clk);
    check("R3 write count", wrCnt - wrBase, 4);
    check("R3 write0 addr", wrAddrLog[wrBase],     32'h20);
    check("R3 write0 data", wrDataLog[wrBase],     32'hD000_0001);
    check("R3 write1 addr", wrAddrLog[wrBase + 1], 32'h24);
    check("R3 write2 data", wrDataLog[wrBase + 2], 32'hD000_0003);
    check("R3 write3 addr", wrAddrLog[wrBase + 3], 32'h28);
    check("R9 empty after drain", {31'd0, sbEmpty}, 32'd1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule